// File: doc/BRIEF.md
# BCD Seven-Segment Driver with Zero Blanking

This block turns one four-bit BCD digit into the seven segment lines of a decimal display. All segment lines are active-low, so a 0 on a line lights that segment. Three active-low controls change the picture. The lamp test lights every segment. The forced blank turns every segment off. The ripple-blank input makes the block suppress a zero digit, and when it does so it pulls its own ripple-blank output low.

Several copies can be chained so that nonessential zeros go dark. For leading zeros, the most significant digit's ripple-blank input is tied low, and each ripple-blank output feeds the ripple-blank input of the next lower digit. The digit just left of the decimal point has its ripple-blank input tied high, so it always shows. Trailing zeros use the same chain in the other direction. The least significant digit starts the chain, and the digit just right of the point is tied high. The block is purely combinational.

Top module: `bcd_seg_driver`

## Requirements
- R1: With no blanking or lamp test in effect, codes 0 to 9 give the usual decimal glyphs on segN, where bit 0 is segment a, then b, c, d, e and f, and bit 6 is segment g, all active-low. Segment a is the top bar, b and c are the right side from top to bottom, d is the bottom bar, e and f are the left side from bottom to top, and g is the middle bar. Digit 6 includes the top bar and digit 9 includes the bottom bar. The values are: 0 → 7'b1000000, 1 → 7'b1111001, 2 → 7'b0100100, 3 → 7'b0110000, 4 → 7'b0011001, 5 → 7'b0010010, 6 → 7'b0000010, 7 → 7'b1111000, 8 → 7'b0000000, 9 → 7'b0010000.
- R2: BCD codes 10 to 15 drive every segment off (segN = 7'b1111111) unless the lamp test is active.
- R3: When lampTestN is 0 and blankInN is 1, segN is 7'b0000000 and rippleOutN is 1. This holds for any code and any ripple-blank input.
- R4: When blankInN is 0, segN is 7'b1111111 and rippleOutN is 0. This overrides the code, the lamp test and the ripple-blank input.
- R5: When blankInN is 1, lampTestN is 1, rippleInN is 0 and the code is 0000, segN is 7'b1111111 and rippleOutN is 0.
- R6: In every other case rippleOutN is 1 and the digit shows as in R1 or R2. This covers a nonzero code, and a zero with rippleInN at 1.
- R7: In a six-digit chain wired for leading-zero suppression, zeros above the first nonzero digit are blank. The digit left of the decimal point always shows.
- R8: In the same chain wired for trailing-zero suppression, zeros below the last nonzero fraction digit are blank. The digit right of the decimal point always shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcdIn | input | 4 | BCD digit code |
| lampTestN | input | 1 | Active-low lamp test, lights all segments |
| blankInN | input | 1 | Active-low forced blank |
| rippleInN | input | 1 | Active-low ripple-blank input, suppresses a zero |
| segN | output | 7 | Active-low segment lines, bit 0 = a to bit 6 = g |
| rippleOutN | output | 1 | Active-low ripple-blank output, low when this digit is dark |

## Verification
The embedded checks are evaluated on every input change. They cover the following:
- A forced blank always yields a dark digit with the ripple output low.
- The lamp test wins over zero suppression.
- Out-of-range codes stay dark.
- A low ripple output never comes with a lit segment.

The exact glyph for each code, and the way zeros vanish across a six-digit chain, are shown only by the bench's scenarios. These scenarios include a 006.400 style readout and the leading-digit and trailing-digit corner values.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef struct packed {
    logic lampAll;  // light every segment
    logic darkAll;  // turn every segment off
  } segStrobeT;
endpackage

// File: rtl/seg_blank_ctrl.sv
module seg_blank_ctrl
  import segdrv_pkg::*;
#(
  parameter int BcdW = BCD_W
) (
  input  logic [BcdW-1:0] bcdIn,
  input  logic            lampTestN,
  input  logic            blankInN,
  input  logic            rippleInN,
  output segStrobeT       strobe,
  output logic            rippleOutN
);
  localparam logic [BcdW-1:0] ZeroCode = '0;

  logic zeroSuppress;
  logic forcedDark;

  always_comb begin
    forcedDark     = !blankInN;
    zeroSuppress   = blankInN && lampTestN && !rippleInN && (bcdIn == ZeroCode);
    strobe.darkAll = forcedDark || zeroSuppress;
    strobe.lampAll = blankInN && !lampTestN;
    rippleOutN     = !strobe.darkAll;
  end

  always_comb begin
    // R4
    forced_blank_dark_chk: assert (blankInN || (strobe.darkAll && !rippleOutN))
      else $error("forced blank not honoured");
    // R3
    if (blankInN && !lampTestN)
      lamp_over_ripple_chk: assert (!strobe.darkAll && rippleOutN)
        else $error("lamp test lost to suppression");
    // R6
    if (blankInN && (bcdIn != ZeroCode))
      nonzero_ripple_high_chk: assert (rippleOutN)
        else $error("nonzero digit pulled ripple low");
  end
endmodule

// File: rtl/seg_glyph_path.sv
module seg_glyph_path
  import segdrv_pkg::*;
#(
  parameter int BcdW = BCD_W,
  parameter int SegW = SEG_W
) (
  input  logic [BcdW-1:0] bcdIn,
  input  segStrobeT       strobe,
  output logic [SegW-1:0] segN
);
  localparam int MaxDigit = 9;

  logic [SegW-1:0] glyphOn;  // active-high, bit0 = a .. bit6 = g

  always_comb begin
    unique case (bcdIn)
      4'd0:    glyphOn = 7'b0111111;
      4'd1:    glyphOn = 7'b0000110;
      4'd2:    glyphOn = 7'b1011011;
      4'd3:    glyphOn = 7'b1001111;
      4'd4:    glyphOn = 7'b1100110;
      4'd5:    glyphOn = 7'b1101101;
      4'd6:    glyphOn = 7'b1111101;
      4'd7:    glyphOn = 7'b0000111;
      4'd8:    glyphOn = 7'b1111111;
      4'd9:    glyphOn = 7'b1101111;
      default: glyphOn = '0;
    endcase
  end

  always_comb begin
    if (strobe.darkAll)      segN = '1;
    else if (strobe.lampAll) segN = '0;
    else                     segN = ~glyphOn;
  end

  always_comb begin
    // R2
    if (!strobe.lampAll && (int'(bcdIn) > MaxDigit))
      bad_code_dark_chk: assert (segN == '1)
        else $error("out-of-range code lit a segment");
    // R1
    if (!strobe.lampAll && !strobe.darkAll && (int'(bcdIn) <= MaxDigit))
      digit_lit_chk: assert (segN != '1)
        else $error("valid digit shows nothing");
  end
endmodule

// File: rtl/bcd_seg_driver.sv
module bcd_seg_driver
  import segdrv_pkg::*;
#(
  parameter int BcdW = BCD_W,
  parameter int SegW = SEG_W
) (
  input  logic [BcdW-1:0] bcdIn,
  input  logic            lampTestN,
  input  logic            blankInN,
  input  logic            rippleInN,
  output logic [SegW-1:0] segN,
  output logic            rippleOutN
);
  segStrobeT strobe;

  seg_blank_ctrl #(.BcdW(BcdW)) ctrl (
    .bcdIn(bcdIn), .lampTestN(lampTestN), .blankInN(blankInN),
    .rippleInN(rippleInN), .strobe(strobe), .rippleOutN(rippleOutN)
  );

  seg_glyph_path #(.BcdW(BcdW), .SegW(SegW)) path (
    .bcdIn(bcdIn), .strobe(strobe), .segN(segN)
  );

  always_comb begin
    // R5
    if (!rippleOutN)
      ripple_low_dark_chk: assert (segN == '1)
        else $error("ripple low while digit lit");
  end
endmodule

// File: tb/bcd_seg_driver_test.sv
module bcd_seg_driver_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] bcdIn;
  logic lampTestN, blankInN, rippleInN;
  logic [6:0] segN;
  logic rippleOutN;

  bcd_seg_driver uut (
    .bcdIn(bcdIn), .lampTestN(lampTestN), .blankInN(blankInN),
    .rippleInN(rippleInN), .segN(segN), .rippleOutN(rippleOutN)
  );

  // six-digit chain: index 5 most significant, point between 3 and 2
  logic [3:0] digitVal [6];
  logic [6:0] chainSeg [6];
  logic       chainRbo [6];
  logic       chainRbi [6];

  always_comb begin
    chainRbi[5] = 1'b0;
    chainRbi[4] = chainRbo[5];
    chainRbi[3] = 1'b1;
    chainRbi[2] = 1'b1;
    chainRbi[1] = chainRbo[0];
    chainRbi[0] = 1'b0;
  end

  for (genvar k = 0; k < 6; k++) begin : g_chain
    bcd_seg_driver dig (
      .bcdIn(digitVal[k]), .lampTestN(1'b1), .blankInN(1'b1),
      .rippleInN(chainRbi[k]), .segN(chainSeg[k]), .rippleOutN(chainRbo[k])
    );
  end

  function automatic logic [6:0] glyphOf(input logic [3:0] c);
    case (c)
      4'd0: return 7'b1000000;
      4'd1: return 7'b1111001;
      4'd2: return 7'b0100100;
      4'd3: return 7'b0110000;
      4'd4: return 7'b0011001;
      4'd5: return 7'b0010010;
      4'd6: return 7'b0000010;
      4'd7: return 7'b1111000;
      4'd8: return 7'b0000000;
      4'd9: return 7'b0010000;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic logic [7:0] expectOf(input logic [3:0] c, input logic lt,
                                           input logic bi, input logic rbi);
    if (!bi) return {1'b0, 7'b1111111};
    if (!lt) return {1'b1, 7'b0000000};
    if (!rbi && c == 4'd0) return {1'b0, 7'b1111111};
    return {1'b1, glyphOf(c)};
  endfunction

  task automatic applyCheck(input logic [3:0] c, input logic lt, input logic bi,
                            input logic rbi, input string req);
    logic [7:0] exp;
    @(posedge clk); #1;
    bcdIn = c; lampTestN = lt; blankInN = bi; rippleInN = rbi;
    #3;
    exp = expectOf(c, lt, bi, rbi);
    checks++;
    if ({rippleOutN, segN} !== exp) begin
      errors++;
      $display("FAIL %s: code=%0d lt=%b bi=%b rbi=%b got rbo=%b seg=%b exp rbo=%b seg=%b",
               req, c, lt, bi, rbi, rippleOutN, segN, exp[7], exp[6:0]);
    end
  endtask

  task automatic chainCheck(input logic [3:0] d5, input logic [3:0] d4,
                            input logic [3:0] d3, input logic [3:0] d2,
                            input logic [3:0] d1, input logic [3:0] d0,
                            input logic [5:0] shownMask);
    @(posedge clk); #1;
    digitVal[5] = d5; digitVal[4] = d4; digitVal[3] = d3;
    digitVal[2] = d2; digitVal[1] = d1; digitVal[0] = d0;
    #3;
    for (int k = 0; k < 6; k++) begin
      logic [6:0] exp;
      exp = shownMask[k] ? glyphOf(digitVal[k]) : 7'b1111111;
      checks++;
      if (chainSeg[k] !== exp) begin
        errors++;
        $display("FAIL %s: digit %0d got seg=%b exp seg=%b",
                 (k >= 3) ? "R7" : "R8", k, chainSeg[k], exp);
      end
    end
  endtask

  initial begin
    bcdIn = '0; lampTestN = 1'b1; blankInN = 1'b1; rippleInN = 1'b1;
    for (int k = 0; k < 6; k++) digitVal[k] = '0;
    // R1 all valid digits, plain drive
    for (int c = 0; c < 10; c++) applyCheck(4'(c), 1'b1, 1'b1, 1'b1, "R1");
    // R2 out-of-range codes, even with ripple-blank low
    for (int c = 10; c < 16; c++) applyCheck(4'(c), 1'b1, 1'b1, 1'b0, "R2");
    // R3 lamp test beats zero suppression and bad codes
    applyCheck(4'd0, 1'b0, 1'b1, 1'b0, "R3");
    applyCheck(4'd15, 1'b0, 1'b1, 1'b1, "R3");
    // R4 forced blank beats everything
    applyCheck(4'd8, 1'b0, 1'b0, 1'b1, "R4");
    applyCheck(4'd0, 1'b1, 1'b0, 1'b1, "R4");
    // R5 zero suppression
    applyCheck(4'd0, 1'b1, 1'b1, 1'b0, "R5");
    // R6 nonzero with ripple low still shows
    applyCheck(4'd1, 1'b1, 1'b1, 1'b0, "R6");
    applyCheck(4'd0, 1'b1, 1'b1, 1'b1, "R6");
    // random mix, fixed seed
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      c = 4'($urandom);
      if (($urandom % 3) == 0) c = 4'd0;
      applyCheck(c, ($urandom % 5) != 0, ($urandom % 6) != 0, 1'($urandom), "R6");
    end
    // R7/R8 chain scenarios: mask bit k = digit k shown
    chainCheck(4'd0, 4'd0, 4'd6, 4'd4, 4'd0, 4'd0, 6'b001100);  // 006.400
    chainCheck(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 6'b001100);  // 000.000
    chainCheck(4'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 6'b111111);  // 100.001
    chainCheck(4'd0, 4'd3, 4'd0, 4'd0, 4'd7, 4'd0, 6'b011110);  // 030.070
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule